// File: doc/BRIEF.md
# Multiplierless Odd-Half Stage for a 32-Point Inverse Integer Transform

This block produces the sixteen odd-half terms of a 32-point inverse integer cosine transform. Its inputs are the sixteen odd-indexed coefficients of one column. It has no multipliers. There are sixteen parallel lanes. In every cycle each lane scales one held input by a constant, using only shifts and additions. The sixteen signed products are summed into one result. Sixteen consecutive cycles deliver the full set of sixteen results.

The first eight results come out in ascending order. For the other eight, the same lanes are reused rather than duplicated. Each lane is fed the mirror-position input with an alternating sign, and the coefficient selections from the first half are walked back in reverse. This yields results 8 through 15. A surrounding transform engine adds the even half and does the final butterfly combine.

Top module: `odd_butterfly32`

## Requirements
- R1: After reset, `out_valid` and `done` are low, and `out_idx` and `out_data` are zero.
- R2: A `start` sampled high at a clock edge while the block is idle captures all sixteen inputs. The input for odd coefficient 2j+1 is `din[16*j +: 16]`, read as two's complement. The first result appears with `out_valid` high at the next clock edge.
- R3: The result with index k equals the sum over j of s·c·x_j, computed exactly. To find c and s, let p = ((2j+1)(2k+1)) mod 128. If p<32, q=p and s=+1. If 32<p<64, q=64−p and s=−1. If 64<p<96, q=p−64 and s=−1. Otherwise q=128−p and s=+1. Then c is magnitude number (q−1)/2 from R9.
- R4: After a start is accepted, `out_valid` stays high for exactly sixteen consecutive cycles. `out_idx` runs 0,1,…,15 in that order, one value per cycle.
- R5: `done` is high only in the cycle that carries index 15, together with `out_valid`.
- R6: `start` is ignored while a computation is in progress, including the cycle in which `done` is issued. Input changes during that time have no effect on the remaining results.
- R7: No result is rounded or truncated. Worst-case inputs of all −32768 or all +32767 give the exact 28-bit signed sum.
- R8: A new `start` is accepted in the cycle right after `done`, and its first result follows with no gap.
- R9: The magnitude list, in order of increasing q, is 90, 90, 88, 85, 82, 78, 73, 67, 61, 54, 46, 38, 31, 22, 13, 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation on `din` when idle |
| din | input | 256 | Sixteen 16-bit odd-indexed inputs, lane j in bits 16j+15:16j |
| out_valid | output | 1 | Result on `out_idx`/`out_data` is valid |
| out_idx | output | 4 | Index of the current result |
| out_data | output | 28 | Exact signed result |
| done | output | 1 | Last result of the set |

## Verification
A request for new work can land in the very cycle that the final result and `done` are issued. It can also land one cycle later, when the block has just gone idle. The bench raises `start` with fresh data exactly on the `done` edge and holds it into the following edge with a third data set. A behavioural model judges the outcome. That model drops the first request because the block is still busy and accepts the second. It then requires sixteen correct results for the third set, following seamlessly, with no trace of the rejected set in them.

// File: rtl/odd_butterfly32.sv
module odd_butterfly32 #(
  parameter int IN_W  = 16,
  parameter int ACC_W = IN_W + 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [16*IN_W-1:0]      din,
  output logic                    out_valid,
  output logic [3:0]              out_idx,
  output logic signed [ACC_W-1:0] out_data,
  output logic                    done
);
  localparam int LANES = 16;
  localparam int PW    = IN_W + 7;
  localparam int PH_W  = 7;

  logic                      busy, pass2;
  logic [2:0]                step;
  logic [LANES*IN_W-1:0]     xbuf;
  logic [LANES*PH_W-1:0]     phv;
  logic [LANES*PW-1:0]       prodv;
  logic signed [ACC_W-1:0]   total, result;

  wire accept = start & ~busy;
  wire last   = busy & pass2 & (step == 3'd0);
  wire hold   = ~pass2 & (step == 3'd7);

  genvar j;
  generate
    for (j = 0; j < LANES; j++) begin : g_lane
      localparam bit ALT = (j % 2) == 1;
      logic [PH_W-1:0]        p, q;
      logic                   neg;
      logic [3:0]             mi;
      logic signed [IN_W-1:0] xin;
      logic signed [PW-1:0]   a, m;

      assign p   = phv[j*PH_W +: PH_W];
      assign xin = pass2 ? xbuf[(LANES-1-j)*IN_W +: IN_W] : xbuf[j*IN_W +: IN_W];
      assign a   = PW'(xin);

      always_comb begin
        if (p < 7'd32) begin
          q = p; neg = 1'b0;
        end else if (p < 7'd64) begin
          q = 7'd64 - p; neg = 1'b1;
        end else if (p < 7'd96) begin
          q = p - 7'd64; neg = 1'b1;
        end else begin
          q = ~p + 7'd1; neg = 1'b0;
        end
        mi = 4'(q >> 1);
      end

      always_comb begin
        case (mi)
          4'd0, 4'd1: m = (a <<< 6) + (a <<< 4) + (a <<< 3) + (a <<< 1);
          4'd2:       m = (a <<< 6) + (a <<< 4) + (a <<< 3);
          4'd3:       m = (a <<< 6) + (a <<< 4) + (a <<< 2) + a;
          4'd4:       m = (a <<< 6) + (a <<< 4) + (a <<< 1);
          4'd5:       m = (a <<< 6) + (a <<< 4) - (a <<< 1);
          4'd6:       m = (a <<< 6) + (a <<< 3) + a;
          4'd7:       m = (a <<< 6) + (a <<< 1) + a;
          4'd8:       m = (a <<< 6) - (a <<< 1) - a;
          4'd9:       m = (a <<< 5) + (a <<< 4) + (a <<< 2) + (a <<< 1);
          4'd10:      m = (a <<< 5) + (a <<< 4) - (a <<< 1);
          4'd11:      m = (a <<< 5) + (a <<< 2) + (a <<< 1);
          4'd12:      m = (a <<< 5) - a;
          4'd13:      m = (a <<< 4) + (a <<< 2) + (a <<< 1);
          4'd14:      m = (a <<< 3) + (a <<< 2) + a;
          default:    m = (a <<< 2);
        endcase
      end

      assign prodv[j*PW +: PW] = (neg ^ (pass2 & ALT)) ? -m : m;
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++)
      total = total + ACC_W'($signed(prodv[i*PW +: PW]));
  end

  assign result = (pass2 & ~step[0]) ? -total : total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xbuf <= '0;
      phv  <= '0;
    end else if (accept) begin
      xbuf <= din;
      for (int i = 0; i < LANES; i++) phv[i*PH_W +: PH_W] <= PH_W'(2*i + 1);
    end else if (busy && !hold) begin
      for (int i = 0; i < LANES; i++)
        phv[i*PH_W +: PH_W] <= pass2 ? phv[i*PH_W +: PH_W] - PH_W'(4*i + 2)
                                     : phv[i*PH_W +: PH_W] + PH_W'(4*i + 2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pass2     <= 1'b0;
      step      <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_data  <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= busy;
      done      <= last;
      if (busy) begin
        out_data <= result;
        out_idx  <= pass2 ? 4'd15 - {1'b0, step} : {1'b0, step};
      end
      if (accept) begin
        busy  <= 1'b1;
        pass2 <= 1'b0;
        step  <= '0;
      end else if (busy) begin
        if (!pass2) begin
          if (hold) pass2 <= 1'b1;
          else      step  <= step + 3'd1;
        end else if (step == 3'd0) begin
          busy  <= 1'b0;
          pass2 <= 1'b0;
        end else begin
          step <= step - 3'd1;
        end
      end
    end
  end

  p_busy_gives_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> out_valid);
  p_index_advances_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx != 4'd15) |=> (out_valid && out_idx == $past(out_idx) + 4'd1));
  p_done_on_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_valid && out_idx == 4'd15));
  p_first_index_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_idx == 4'd0));
  p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(xbuf));
endmodule

// File: tb/odd_butterfly32_bench.sv
module odd_butterfly32_bench;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [255:0]       din = '0;
  logic               out_valid, done;
  logic [3:0]         out_idx;
  logic signed [27:0] out_data;

  always #2 clk = ~clk;

  odd_butterfly32 u_odd_butterfly32 (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data), .done(done));

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0, watching = 0;

  bit     m_busy = 0;
  int     m_cnt = 0;
  int     m_x[16];
  bit     e_valid = 0, e_done = 0;
  int     e_idx = 0;
  longint e_val = 0;

  // R9 magnitude list
  function automatic int mag(input int n);
    case (n)
      0, 1: return 90;  2: return 88;  3: return 85;  4: return 82;
      5: return 78;     6: return 73;  7: return 67;  8: return 61;
      9: return 54;     10: return 46; 11: return 38; 12: return 31;
      13: return 22;    14: return 13; default: return 4;
    endcase
  endfunction

  // R3 reference sum
  function automatic longint refval(input int k);
    longint s = 0;
    for (int j = 0; j < 16; j++) begin
      int p, q, sg;
      p = ((2*j+1)*(2*k+1)) % 128;
      if (p < 32)      begin q = p;       sg = 1;  end
      else if (p < 64) begin q = 64 - p;  sg = -1; end
      else if (p < 96) begin q = p - 64;  sg = -1; end
      else             begin q = 128 - p; sg = 1;  end
      s += longint'(sg) * mag((q-1)/2) * m_x[j];
    end
    return s;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; e_valid = 0; e_done = 0;
    end else begin
      e_valid = 0; e_done = 0;
      if (m_busy) begin
        e_valid = 1; e_idx = m_cnt; e_val = refval(m_cnt); e_done = (m_cnt == 15);
        if (m_cnt == 15) m_busy = 0; else m_cnt++;
      end else if (start) begin
        for (int j = 0; j < 16; j++) m_x[j] = int'($signed(din[16*j +: 16]));
        m_busy = 1; m_cnt = 0;
      end
    end
    if (cyc > 20000 && !finished) begin
      finished = 1; fails++;
      $display("FAIL watchdog: actual cycles %0d expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) if (watching) begin
    checks++;
    if (out_valid !== e_valid) begin
      fails++; $display("FAIL R2 R4 out_valid: actual %0b expected %0b", out_valid, e_valid);
    end
    checks++;
    if (done !== e_done) begin
      fails++; $display("FAIL R5 done: actual %0b expected %0b", done, e_done);
    end
    if (e_valid) begin
      checks++;
      if (int'(out_idx) != e_idx) begin
        fails++; $display("FAIL R4 out_idx: actual %0d expected %0d", out_idx, e_idx);
      end
      checks++;
      if (longint'(out_data) != e_val) begin
        fails++; $display("FAIL R3 R7 value idx %0d: actual %0d expected %0d", e_idx, out_data, e_val);
      end
    end
  end

  task automatic load(input int v[16]);
    for (int j = 0; j < 16; j++) din[16*j +: 16] = 16'(v[j]);
  endtask

  task automatic send(input int v[16]);
    @(negedge clk); load(v); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  int v[16], b[16], c[16];
  int seed = 12345;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || done !== 1'b0 || out_idx !== 4'd0 || out_data !== '0) begin
      fails++; $display("FAIL R1 reset: actual v%0b d%0b i%0d x%0d expected 0 0 0 0",
                        out_valid, done, out_idx, out_data);
    end
    rst_n = 1'b1;
    watching = 1;
    // R9 single-lane impulses expose each magnitude with its sign
    for (int t = 0; t < 16; t++) begin
      for (int j = 0; j < 16; j++) v[j] = (j == t) ? 1 : 0;
      send(v); repeat (17) @(negedge clk);
    end
    // R7 extremes
    for (int j = 0; j < 16; j++) v[j] = -32768;
    send(v); repeat (17) @(negedge clk);
    for (int j = 0; j < 16; j++) v[j] = 32767;
    send(v); repeat (17) @(negedge clk);
    for (int j = 0; j < 16; j++) v[j] = (j % 2) ? -32768 : 32767;
    send(v); repeat (17) @(negedge clk);
    for (int j = 0; j < 16; j++) v[j] = 1000 * j - 7000;
    send(v); repeat (17) @(negedge clk);
    // R3 pseudo-random sets
    for (int r = 0; r < 6; r++) begin
      for (int j = 0; j < 16; j++) begin
        seed = seed * 1103515245 + 12345;
        v[j] = int'($signed(16'(seed >>> 8)));
      end
      send(v); repeat (17) @(negedge clk);
    end
    // R6 start while busy, R8 back-to-back on the cycle after done
    for (int j = 0; j < 16; j++) begin v[j] = 300 - 41*j; b[j] = 32767; c[j] = -5*j*j + 11; end
    send(v);
    repeat (4) @(negedge clk);
    load(b); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    load(b); start = 1'b1;
    @(negedge clk); load(c);
    @(negedge clk); start = 1'b0; load(b);
    repeat (18) @(negedge clk);
    watching = 0;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule